// File: doc/BRIEF.md
# USB Node Power State Controller

This block keeps track of which operating state a full-speed USB function is in: held in reset, running normally, suspended for lack of bus traffic, or driving a remote-wake resume on the upstream port. Firmware requests state changes through a small command input, while the line-state logic elsewhere on the chip supplies one-cycle detection pulses for bus reset, suspend and resume, together with a bus-activity pulse. Leaving normal operation or coming back from suspend needs both halves: the detected bus condition and the matching firmware command.

An internal idle timer measures how long the upstream port has been quiet. Once it has seen five milliseconds without activity it raises a flag that allows a local wake-up event to start resume signaling. The resume phase lasts a fixed, parameterised number of cycles, after which the node returns to operation by itself. Outside the operational state the block asserts an endpoint-disable output that keeps port registers and endpoint logic inactive.

Top module: `usb_node_pwr_ctrl`

## Requirements
- R1: While rst_n is low and in the first cycle after it, node_state reads 2'b00 (reset), ep_disable is 1, wake_ok is 0 and all three event flags are 0.
- R2: State changes take effect on the clock edge that samples the command. From reset (00), only a command with cmd_state 2'b10 (operational) moves the node, to operational; any command code that is not valid for the current state, including 2'b01 at any time, leaves the state unchanged.
- R3: Operational (10) moves to suspend (11) only when a command with cmd_state 2'b11 is sampled in the same cycle as suspend_det or after a suspend_det seen while operational; the command alone is ignored.
- R4: A bus_activity pulse after a suspend_det and before the suspend command cancels that detection, so the later command alone is ignored.
- R5: Suspend (11) moves to operational (10) only when a command with cmd_state 2'b10 is sampled in the same cycle as resume_det or after a resume_det seen during this suspend; the command alone is ignored.
- R6: wake_ok rises exactly IDLE_TICKS*TICK_DIV clock edges after the edge that sampled the last bus_activity pulse (or after reset release), and bus_activity clears it.
- R7: In suspend, local_wake moves the node to resume (01) when wake_ok is 1 and is ignored when wake_ok is 0.
- R8: The resume state lasts exactly RESUME_CYC cycles, then the node enters operational without any command.
- R9: A command with cmd_state 2'b00 moves the node to reset from any state and takes priority over every other transition.
- R10: ep_disable is 1 in every state except operational and 0 in operational.
- R11: evt_bus_reset, evt_suspend and evt_resume are each 1 for exactly the cycle after bus_reset_det, suspend_det or resume_det respectively is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (48 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Firmware set-state command strobe |
| cmd_state | input | 2 | Requested state: 00 reset, 10 operational, 11 suspend |
| bus_reset_det | input | 1 | Bus reset detected pulse |
| suspend_det | input | 1 | Bus suspend condition detected pulse |
| resume_det | input | 1 | Resume signaling from host detected pulse |
| bus_activity | input | 1 | Any activity on the upstream port; restarts idle timing |
| local_wake | input | 1 | Local wake-up event pulse |
| node_state | output | 2 | Current state: 00 reset, 10 operational, 11 suspend, 01 resume |
| ep_disable | output | 1 | Holds endpoint pipes and port registers inactive |
| evt_bus_reset | output | 1 | Bus reset event flag |
| evt_suspend | output | 1 | Suspend event flag |
| evt_resume | output | 1 | Resume event flag |
| wake_ok | output | 1 | Five-millisecond idle reached; remote wake permitted |

## Verification
The bench builds the block with TICK_DIV=4, IDLE_TICKS=5 and RESUME_CYC=6, so the idle flag rises twenty edges after activity and a resume phase lasts six cycles. With those values the exact rising edge of wake_ok, a local wake refused before it and accepted after it, and the automatic return from resume all fall within a few dozen cycles. The defaults (one-millisecond tick at 48 MHz, ten-millisecond resume) change only counter limits, not the sequencing that these short values exercise.

// File: rtl/node_pwr_pkg.sv
// Shared definitions for the USB node power state controller.
// Assumes a two-bit state code that firmware commands reuse as-is.
package node_pwr_pkg;
    typedef enum logic [1:0] {
        ST_RESET  = 2'b00,
        ST_RESUME = 2'b01,
        ST_OPER   = 2'b10,
        ST_SUSP   = 2'b11
    } node_state_t;
endpackage

// File: rtl/node_idle_timer.sv
// Idle timer: a prescaler produces a periodic tick, ticks are counted
// while the upstream port stays quiet, and a flag is raised once
// IDLE_TICKS ticks have elapsed. Any bus activity restarts everything.
// Assumes TICK_DIV >= 2 and IDLE_TICKS >= 1.
module node_idle_timer #(
    parameter int TICK_DIV   = 48000,
    parameter int IDLE_TICKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_activity,
    output logic idle_reached
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam int IW = $clog2(IDLE_TICKS + 1);

    logic [PW-1:0] pre_cnt;
    logic [IW-1:0] tick_cnt;
    logic          tick;

    // Tick on the last count of the prescaler period.
    assign tick = (pre_cnt == PW'(TICK_DIV - 1));

    // Prescaler, saturating tick counter and sticky idle flag.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_activity) begin
            pre_cnt      <= '0;
            tick_cnt     <= '0;
            idle_reached <= 1'b0;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
            if (tick && tick_cnt != IW'(IDLE_TICKS)) begin
                tick_cnt <= tick_cnt + 1'b1;
            end
            if (tick && tick_cnt == IW'(IDLE_TICKS - 1)) begin
                idle_reached <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/node_resume_timer.sv
// Resume duration timer: preloaded while idle, counts down while the
// node is driving resume, and reports done on the final cycle.
// Assumes RESUME_CYC >= 2.
module node_resume_timer #(
    parameter int RESUME_CYC = 480000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int RW = $clog2(RESUME_CYC);

    logic [RW-1:0] remain;

    // Last cycle of the resume window.
    assign done = run && (remain == '0);

    // Preload when not running, count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            remain <= RW'(RESUME_CYC - 1);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/node_state_fsm.sv
// Node state machine: combines firmware commands with latched bus
// detections, accepts local wake when the idle flag allows it, and
// produces one-cycle event flags. Assumes detection inputs are
// synchronous to clk.
module node_state_fsm
    import node_pwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_state,
    input  logic        bus_reset_det,
    input  logic        suspend_det,
    input  logic        resume_det,
    input  logic        bus_activity,
    input  logic        local_wake,
    input  logic        wake_ok,
    input  logic        resume_done,
    output node_state_t state,
    output logic        evt_bus_reset,
    output logic        evt_suspend,
    output logic        evt_resume
);
    node_state_t nxt;
    logic        susp_seen;
    logic        res_seen;
    logic        want_reset;
    logic        want_oper;
    logic        want_susp;

    // Decode the firmware command.
    assign want_reset = cmd_valid && (cmd_state == 2'b00);
    assign want_oper  = cmd_valid && (cmd_state == 2'b10);
    assign want_susp  = cmd_valid && (cmd_state == 2'b11);

    // Next-state selection; a reset command outranks everything.
    always_comb begin
        nxt = state;
        if (want_reset) begin
            nxt = ST_RESET;
        end else begin
            case (state)
                ST_RESET:  if (want_oper) nxt = ST_OPER;
                ST_OPER:   if (want_susp && (susp_seen || suspend_det)) nxt = ST_SUSP;
                ST_SUSP: begin
                    if (want_oper && (res_seen || resume_det)) nxt = ST_OPER;
                    else if (local_wake && wake_ok)            nxt = ST_RESUME;
                end
                ST_RESUME: if (resume_done) nxt = ST_OPER;
                default:   nxt = ST_RESET;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    // Remember a suspend detection until used, cancelled or left behind.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_OPER || nxt != ST_OPER || bus_activity) begin
            susp_seen <= 1'b0;
        end else if (suspend_det) begin
            susp_seen <= 1'b1;
        end
    end

    // Remember a resume detection for the current suspend only.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_SUSP || nxt != ST_SUSP) begin
            res_seen <= 1'b0;
        end else if (resume_det) begin
            res_seen <= 1'b1;
        end
    end

    // One-cycle event flags following each detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_bus_reset <= 1'b0;
            evt_suspend   <= 1'b0;
            evt_resume    <= 1'b0;
        end else begin
            evt_bus_reset <= bus_reset_det;
            evt_suspend   <= suspend_det;
            evt_resume    <= resume_det;
        end
    end
endmodule

// File: rtl/usb_node_pwr_ctrl.sv
// Top of the USB node power state controller. Ties the idle timer,
// resume timer and state machine together and derives endpoint
// disable. Assumes all inputs are synchronous to clk.
module usb_node_pwr_ctrl
    import node_pwr_pkg::*;
#(
    parameter int TICK_DIV   = 48000,
    parameter int IDLE_TICKS = 5,
    parameter int RESUME_CYC = 480000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_state,
    input  logic       bus_reset_det,
    input  logic       suspend_det,
    input  logic       resume_det,
    input  logic       bus_activity,
    input  logic       local_wake,
    output logic [1:0] node_state,
    output logic       ep_disable,
    output logic       evt_bus_reset,
    output logic       evt_suspend,
    output logic       evt_resume,
    output logic       wake_ok
);
    node_state_t state;
    logic        resume_done;

    node_idle_timer #(
        .TICK_DIV   (TICK_DIV),
        .IDLE_TICKS (IDLE_TICKS)
    ) u_idle (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_activity (bus_activity),
        .idle_reached (wake_ok)
    );

    node_resume_timer #(
        .RESUME_CYC (RESUME_CYC)
    ) u_resume (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_RESUME),
        .done  (resume_done)
    );

    node_state_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_state     (cmd_state),
        .bus_reset_det (bus_reset_det),
        .suspend_det   (suspend_det),
        .resume_det    (resume_det),
        .bus_activity  (bus_activity),
        .local_wake    (local_wake),
        .wake_ok       (wake_ok),
        .resume_done   (resume_done),
        .state         (state),
        .evt_bus_reset (evt_bus_reset),
        .evt_suspend   (evt_suspend),
        .evt_resume    (evt_resume)
    );

    // Outputs derived from the state register.
    assign node_state = state;
    assign ep_disable = (state != ST_OPER);
endmodule

// File: rtl/node_pwr_chk.sv
// Checker for the node power state controller, bound to the top.
// Observes ports only and keeps its own resume-length counter.
module node_pwr_chk #(
    parameter int RESUME_CYC = 480000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_state,
    input logic       local_wake,
    input logic       wake_ok,
    input logic [1:0] node_state
);
    localparam logic [1:0] C_RESET  = 2'b00;
    localparam logic [1:0] C_RESUME = 2'b01;
    localparam logic [1:0] C_OPER   = 2'b10;
    localparam logic [1:0] C_SUSP   = 2'b11;

    logic [31:0] res_len;

    // Count consecutive cycles spent in resume.
    always_ff @(posedge clk) begin
        if (!rst_n || node_state != C_RESUME) res_len <= '0;
        else                                  res_len <= res_len + 1;
    end

    a_r2_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(node_state) == C_RESET && node_state != C_RESET) |-> node_state == C_OPER);

    a_r3_susp_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (node_state == C_SUSP && $past(node_state) == C_OPER)
        |-> $past(cmd_valid && cmd_state == C_SUSP));

    a_r5_oper_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (node_state == C_OPER && $past(node_state) == C_SUSP)
        |-> $past(cmd_valid && cmd_state == C_OPER));

    a_r7_wake_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (node_state == C_RESUME && $past(node_state) == C_SUSP)
        |-> $past(local_wake && wake_ok));

    a_r8_resume_len: assert property (@(posedge clk) disable iff (!rst_n)
        res_len <= 32'(RESUME_CYC));
endmodule

bind usb_node_pwr_ctrl node_pwr_chk #(.RESUME_CYC(RESUME_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_state  (cmd_state),
    .local_wake (local_wake),
    .wake_ok    (wake_ok),
    .node_state (node_state)
);

// File: tb/usb_node_pwr_ctrl_tb.sv
module usb_node_pwr_ctrl_tb;
    localparam int TD = 4;
    localparam int IT = 5;
    localparam int RC = 6;
    localparam int NV = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_state = 2'b00;
    logic       bus_reset_det = 1'b0;
    logic       suspend_det = 1'b0;
    logic       resume_det = 1'b0;
    logic       bus_activity = 1'b0;
    logic       local_wake = 1'b0;
    logic [1:0] node_state;
    logic       ep_disable, evt_bus_reset, evt_suspend, evt_resume, wake_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    usb_node_pwr_ctrl #(.TICK_DIV(TD), .IDLE_TICKS(IT), .RESUME_CYC(RC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_state(cmd_state),
        .bus_reset_det(bus_reset_det), .suspend_det(suspend_det),
        .resume_det(resume_det), .bus_activity(bus_activity),
        .local_wake(local_wake), .node_state(node_state), .ep_disable(ep_disable),
        .evt_bus_reset(evt_bus_reset), .evt_suspend(evt_suspend),
        .evt_resume(evt_resume), .wake_ok(wake_ok)
    );

    // {cmd_valid, cmd_state, bus_reset_det, suspend_det, resume_det,
    //  bus_activity, local_wake, expected state, expected ep_disable}
    localparam logic [10:0] VEC [NV] = '{
        11'b1_11_00000_00_1,  // 0  R2 suspend cmd in reset ignored
        11'b1_10_00000_10_0,  // 1  R2 reset -> oper
        11'b1_11_00000_10_0,  // 2  R3 command alone ignored
        11'b0_00_01000_10_0,  // 3  R3 detection latched
        11'b0_00_00010_10_0,  // 4  R4 activity cancels
        11'b1_11_00000_10_0,  // 5  R4 command now ignored
        11'b1_11_01000_11_1,  // 6  R3 same-cycle detect + cmd
        11'b1_10_00000_11_1,  // 7  R5 command alone ignored
        11'b0_00_00001_11_1,  // 8  R7 wake without idle ignored
        11'b0_00_00100_11_1,  // 9  R5 resume detected
        11'b1_10_00000_10_0,  // 10 R5 suspend -> oper
        11'b1_01_00000_10_0,  // 11 R2 code 01 ignored
        11'b0_00_01000_10_0,  // 12 R3 detection latched
        11'b1_11_00000_11_1,  // 13 R3 oper -> suspend
        11'b1_00_10000_00_1,  // 14 R9 reset from suspend, R11 bus reset flag
        11'b1_10_00000_10_0,  // 15 R2
        11'b1_00_00000_00_1,  // 16 R9 reset from oper
        11'b1_10_00000_10_0,  // 17 R2
        11'b1_11_01000_11_1,  // 18 R3
        11'b1_10_00100_10_0   // 19 R5 same-cycle resume + cmd
    };

    function automatic string row_req(int r);
        case (r)
            0, 1, 11, 15, 17: return "R2";
            2, 3, 6, 12, 13, 18: return "R3";
            4, 5: return "R4";
            8: return "R7";
            14, 16: return "R9";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic cv, input logic [1:0] cs, input logic br,
                         input logic sd, input logic rd, input logic ac, input logic lw);
        @(negedge clk);
        cmd_valid = cv; cmd_state = cs; bus_reset_det = br;
        suspend_det = sd; resume_det = rd; bus_activity = ac; local_wake = lw;
        @(posedge clk);
        #2;
    endtask

    task automatic idle_cycle();
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: state during reset
        chk("R1 state", int'(node_state), 0);
        chk("R1 ep_disable", int'(ep_disable), 1);
        chk("R1 wake_ok", int'(wake_ok), 0);
        chk("R1 events", int'({evt_bus_reset, evt_suspend, evt_resume}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk("R1 state after release", int'(node_state), 0);
        chk("R1 ep_disable after release", int'(ep_disable), 1);

        // Table walk: one vector per cycle.
        for (int r = 0; r < NV; r++) begin
            logic [10:0] v;
            v = VEC[r];
            drive(v[10], v[9:8], v[7], v[6], v[5], v[4], v[3]);
            chk(row_req(r), int'(node_state), int'(v[2:1]));
            chk("R10 ep_disable", int'(ep_disable), int'(v[0]));
            chk("R11 evt_bus_reset", int'(evt_bus_reset), int'(v[7]));
            chk("R11 evt_suspend", int'(evt_suspend), int'(v[6]));
            chk("R11 evt_resume", int'(evt_resume), int'(v[5]));
        end

        // R11: flags last one cycle only.
        idle_cycle();
        chk("R11 flags clear", int'({evt_bus_reset, evt_suspend, evt_resume}), 0);

        // Enter suspend, then time the idle flag.
        drive(1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 enter suspend", int'(node_state), 3);
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6 cleared by activity", int'(wake_ok), 0);
        for (int i = 1; i <= IT * TD; i++) begin
            idle_cycle();
            if (i == IT * TD - 1) chk("R6 not yet", int'(wake_ok), 0);
            if (i == IT * TD)     chk("R6 reached", int'(wake_ok), 1);
        end

        // Local wake accepted; resume lasts RC cycles.
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7 wake accepted", int'(node_state), 1);
        chk("R10 ep_disable in resume", int'(ep_disable), 1);
        for (int i = 1; i <= RC; i++) begin
            idle_cycle();
            if (i < RC) chk("R8 still resuming", int'(node_state), 1);
            else        chk("R8 back to operational", int'(node_state), 2);
        end
        chk("R10 ep_disable operational", int'(ep_disable), 0);

        // R9: reset command aborts resume.
        drive(1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 suspend again", int'(node_state), 3);
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7 second wake", int'(node_state), 1);
        drive(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 reset during resume", int'(node_state), 0);
        idle_cycle();
        chk("R9 stays in reset", int'(node_state), 0);

        // R6: activity drops the idle flag.
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6 flag dropped", int'(wake_ok), 0);

        finished = 1;
        report();
    end
endmodule